// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block sits beside a floating-point datapath and settles the result of a two-operand operation when at least one operand has been tagged as a NaN by the upstream classifier. It takes the two 80-bit extended-precision operands, one NaN tag per operand, a caller-supplied default NaN and the invalid-operation mask bit. It then decides three things: which value is written to the destination, whether an invalid-operation exception is raised, and whether the write is suppressed because that exception is unmasked.

All operands use the same layout. Bit 79 is the sign, bits 78:64 are the exponent, and bits 63:0 are the significand. Bit 63 of the significand is the explicit integer bit and bit 62 is the quiet bit. An operand is a genuine NaN when its exponent is all ones and its integer bit is set. The built-in quiet NaN constant has sign 1, exponent 0x7FFF and significand 0xC000_0000_0000_0000.

The selection logic is purely combinational. Its decision is captured in one register stage, so a result appears on the cycle after the request.

Top module: `nan_pick`

## Requirements
- R1: When exactly one operand is tagged NaN and it is a genuine quiet NaN (bit 62 set), that operand is written unchanged and invalid is not raised.
- R2: When a tagged operand is not a genuine NaN (the exponent is not all ones or bit 63 is clear), invalid is raised. If invalid is masked, the built-in quiet NaN constant is written. If invalid is unmasked, nothing is written and the fault flag is set.
- R3: When both operands are genuine NaNs, the operand with the larger unsigned 64-bit significand is selected, whatever the signs.
- R4: When both operands are genuine NaNs with equal significands, the default NaN input is selected. The signs may differ.
- R5: When any genuine NaN that takes part in the choice is signalling (bit 62 clear), invalid is raised. With invalid masked, the selected value is written with bit 62 forced to 1.
- R6: In a signalling case with invalid unmasked, the destination is not written and the fault flag is set.
- R7: A selected value whose bit 63 is clear is replaced by the built-in quiet NaN constant.
- R8: When neither operand is tagged NaN, nothing is written, invalid is not raised and the fault flag is clear.
- R9: The result appears one cycle after the request. out_valid follows in_valid, and all flags and the result are zero while out_valid is low and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| a_val | input | 80 | First operand (also the destination's current value) |
| a_nan | input | 1 | First operand is tagged NaN |
| b_val | input | 80 | Second operand |
| b_nan | input | 1 | Second operand is tagged NaN |
| dflt_nan | input | 80 | Value used when both significands are equal |
| inv_mask | input | 1 | Invalid-operation exception masked |
| out_valid | output | 1 | Result valid |
| out_res | output | 80 | Value to write to the destination |
| out_write | output | 1 | Destination write enable |
| out_raise | output | 1 | Invalid-operation exception raised |
| out_fault | output | 1 | Unmasked exception, write suppressed |

## Verification
The checker checks the flag relations on every cycle:
- a fault never comes with a write and always comes with a raise;
- a written value always has its integer bit set, and is also quiet whenever invalid was raised;
- a masked request never faults;
- an idle output stage stays all zero;
- out_valid tracks in_valid with one cycle of delay.

Which operand wins is left to the bench's scenarios. These cover significand ordering, equal significands with differing signs, a default NaN without the integer bit, pseudo-NaNs and non-NaN tags.

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [EXP_W+SIG_W:0]         a_val,
  input  logic                         a_nan,
  input  logic [EXP_W+SIG_W:0]         b_val,
  input  logic                         b_nan,
  input  logic [EXP_W+SIG_W:0]         dflt_nan,
  input  logic                         inv_mask,
  output logic                         out_valid,
  output logic [EXP_W+SIG_W:0]         out_res,
  output logic                         out_write,
  output logic                         out_raise,
  output logic                         out_fault
);
  localparam int W    = EXP_W + SIG_W + 1;
  localparam int IBIT = SIG_W - 1;
  localparam int QBIT = SIG_W - 2;
  localparam logic [W-1:0] QNAN_K =
    {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic a_real, b_real, bad_enc;
  logic [SIG_W-1:0] a_sig, b_sig;
  logic [W-1:0] pick, fixed;
  logic sig_case, n_write, n_raise, n_fault;
  logic [W-1:0] n_res;

  assign a_sig   = a_val[SIG_W-1:0];
  assign b_sig   = b_val[SIG_W-1:0];
  assign a_real  = (&a_val[SIG_W +: EXP_W]) & a_val[IBIT];
  assign b_real  = (&b_val[SIG_W +: EXP_W]) & b_val[IBIT];
  assign bad_enc = (a_nan & ~a_real) | (b_nan & ~b_real);

  always_comb begin
    pick     = b_val;
    sig_case = 1'b0;
    if (a_nan && b_nan) begin
      sig_case = ~(a_val[QBIT] & b_val[QBIT]);
      if (b_sig > a_sig)       pick = b_val;
      else if (b_sig == a_sig) pick = dflt_nan;
      else                     pick = a_val;
    end else if (a_nan) begin
      sig_case = ~a_val[QBIT];
      pick     = a_val;
    end else begin
      sig_case = ~b_val[QBIT];
      pick     = b_val;
    end
  end

  assign fixed = pick[IBIT] ? pick : QNAN_K;

  always_comb begin
    n_res   = '0;
    n_write = 1'b0;
    n_raise = 1'b0;
    n_fault = 1'b0;
    if (!(a_nan || b_nan)) begin
      n_write = 1'b0;
    end else if (bad_enc) begin
      n_raise = 1'b1;
      n_write = inv_mask;
      n_fault = ~inv_mask;
      n_res   = inv_mask ? QNAN_K : '0;
    end else if (!sig_case || inv_mask) begin
      n_write = 1'b1;
      n_raise = sig_case;
      n_res   = fixed;
      if (sig_case) n_res[QBIT] = 1'b1;
    end else begin
      n_raise = 1'b1;
      n_fault = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_write <= 1'b0;
      out_raise <= 1'b0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_res   <= in_valid ? n_res   : '0;
      out_write <= in_valid & n_write;
      out_raise <= in_valid & n_raise;
      out_fault <= in_valid & n_fault;
    end
  end
endmodule

// File: rtl/nan_pick_chk.sv
module nan_pick_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 inv_mask,
  input logic                 out_valid,
  input logic [EXP_W+SIG_W:0] out_res,
  input logic                 out_write,
  input logic                 out_raise,
  input logic                 out_fault
);
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> (!out_write && out_raise)); // R6
  AST_WRITE_HAS_IBIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_write |-> out_res[SIG_W-1]); // R7
  AST_RAISED_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_write && out_raise) |-> out_res[SIG_W-2]); // R5
  AST_MASKED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inv_mask) |=> !out_fault); // R2
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_write && !out_raise && !out_fault && out_res == '0)); // R9
endmodule

bind nan_pick nan_pick_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mask(inv_mask),
  .out_valid(out_valid), .out_res(out_res), .out_write(out_write),
  .out_raise(out_raise), .out_fault(out_fault)
);

// File: tb/test_nan_pick.sv
module test_nan_pick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] a_val = '0, b_val = '0, dflt_nan = '0;
  logic        a_nan = 1'b0, b_nan = 1'b0, inv_mask = 1'b0;
  logic        out_valid, out_write, out_raise, out_fault;
  logic [79:0] out_res;

  localparam logic [79:0] QK = {1'b1, 15'h7fff, 64'hC000_0000_0000_0000};

  typedef struct {
    logic [79:0] res;
    logic        wr;
    logic        rs;
    logic        ft;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nan_pick i_nan_pick (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_val(a_val), .a_nan(a_nan), .b_val(b_val), .b_nan(b_nan),
    .dflt_nan(dflt_nan), .inv_mask(inv_mask), .out_valid(out_valid),
    .out_res(out_res), .out_write(out_write), .out_raise(out_raise),
    .out_fault(out_fault)
  );

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e,
                                     input logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic exp_t model(input logic [79:0] a, input logic ta,
                                 input logic [79:0] b, input logic tb,
                                 input logic [79:0] d, input logic m,
                                 input string tag);
    exp_t r;
    logic ga, gb, sg;
    logic [79:0] x;
    r.res = '0; r.wr = 0; r.rs = 0; r.ft = 0; r.tag = tag;
    ga = (a[78:64] == 15'h7fff) && a[63];
    gb = (b[78:64] == 15'h7fff) && b[63];
    if (!ta && !tb) return r;
    if ((ta && !ga) || (tb && !gb)) begin
      r.rs = 1; r.wr = m; r.ft = !m; r.res = m ? QK : '0;
      return r;
    end
    if (ta && tb) begin
      sg = !a[62] || !b[62];
      x = (b[63:0] > a[63:0]) ? b : ((b[63:0] < a[63:0]) ? a : d);
    end else begin
      x = ta ? a : b;
      sg = !x[62];
    end
    if (sg && !m) begin
      r.rs = 1; r.ft = 1;
      return r;
    end
    if (!x[63]) x = QK;
    if (sg) x[62] = 1'b1;
    r.res = x; r.wr = 1; r.rs = sg;
    return r;
  endfunction

  task automatic send(input logic [79:0] a, input logic ta,
                      input logic [79:0] b, input logic tb,
                      input logic [79:0] d, input logic m, input string tag);
    @(negedge clk);
    a_val = a; a_nan = ta; b_val = b; b_nan = tb; dflt_nan = d; inv_mask = m;
    in_valid = 1'b1;
    sb.push_back(model(a, ta, b, tb, d, m, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected out_valid act=1 exp=0");
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (out_res !== e.res || out_write !== e.wr ||
                out_raise !== e.rs || out_fault !== e.ft) begin
              errors++;
              $display("FAIL %s act res=%h w=%b r=%b f=%b exp res=%h w=%b r=%b f=%b",
                       e.tag, out_res, out_write, out_raise, out_fault,
                       e.res, e.wr, e.rs, e.ft);
            end
          end
        end else if (out_write || out_raise || out_fault || out_res != '0) begin
          checks++;
          errors++;
          $display("FAIL R9 idle outputs act w=%b r=%b f=%b res=%h exp zero",
                   out_write, out_raise, out_fault, out_res);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [79:0] qa, qb, sa, num, pseudo, dq, dpseudo;
    qa      = mk(0, 15'h7fff, 64'hC000_0000_0000_1234);
    qb      = mk(1, 15'h7fff, 64'hC800_0000_0000_0001);
    sa      = mk(0, 15'h7fff, 64'h8000_0000_0000_0055);
    num     = mk(0, 15'h3fff, 64'h8000_0000_0000_0000);
    pseudo  = mk(0, 15'h7fff, 64'h4000_0000_0000_0007);
    dq      = mk(0, 15'h7fff, 64'hE000_0000_0000_0000);
    dpseudo = mk(0, 15'h7fff, 64'h6000_0000_0000_0000);

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || out_write || out_raise || out_fault || out_res != '0) begin
      errors++;
      $display("FAIL R9 reset state act v=%b res=%h exp zero", out_valid, out_res);
    end
    rst_n = 1'b1;

    send(qa, 1, num, 0, dq, 0, "R1 a only quiet");
    send(num, 0, qb, 1, dq, 0, "R1 b only quiet");
    idle();
    send(qa, 1, qb, 1, dq, 0, "R3 b larger");
    send(qb, 1, qa, 1, dq, 1, "R3 a larger");
    send(mk(1, 15'h7fff, 64'hC000_0000_0000_0042), 1,
         mk(0, 15'h7fff, 64'hC000_0000_0000_0042), 1, dq, 0, "R4 equal sigs");
    send(sa, 1, num, 0, dq, 1, "R5 masked signalling");
    send(qb, 1, sa, 1, dq, 1, "R5 b signalling, a wins");
    send(sa, 1, num, 0, dq, 0, "R6 unmasked signalling");
    send(qa, 1, sa, 1, dq, 0, "R6 both, one signalling");
    idle(); idle();
    send(pseudo, 1, qb, 1, dq, 1, "R2 pseudo masked");
    send(qa, 1, pseudo, 1, dq, 0, "R2 pseudo unmasked");
    send(qa, 1, mk(0, 15'h1234, 64'hC000_0000_0000_0000), 1, dq, 1,
         "R2 tagged non-NaN exponent");
    send(mk(0, 15'h7fff, 64'hC000_0000_0000_0009), 1,
         mk(1, 15'h7fff, 64'hC000_0000_0000_0009), 1, dpseudo, 0,
         "R7 default lacks integer bit");
    send(mk(0, 15'h7fff, 64'h8000_0000_0000_0009), 1,
         mk(1, 15'h7fff, 64'h8000_0000_0000_0009), 1, dpseudo, 1,
         "R7 masked signalling default");
    send(num, 0, num, 0, dq, 1, "R8 neither tagged");
    send(num, 0, num, 0, dq, 0, "R8 neither tagged unmasked");
    idle();
    for (int i = 0; i < 20; i++) begin
      logic [79:0] x, y;
      x = mk(i[0], 15'h7fff, {1'b1, i[1], 46'd0, 16'(i * 37)});
      y = mk(i[2], 15'h7fff, {1'b1, i[3], 46'd0, 16'(i * 53 % 97)});
      send(x, 1, y, 1, dq, i[4], "R9 back-to-back stream");
    end
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing act=%0d exp=0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule